// File: doc/BRIEF.md
# Segment Register Load Checker

This unit screens a request to place a selector into one of the eight segment-style registers: the code, stack, four data registers, the local table register and the task register. The descriptor has already been fetched and decoded by the caller, so the unit sees only the selector, the current privilege level, a 64-bit-mode flag, the byte limit of the descriptor table, and the decoded descriptor attributes. It decides whether the load may proceed and, if not, which rule was broken.

Several checks run side by side: a null-selector screen, a table-limit bound, a destination-specific type rule, a destination-specific privilege rule and a presence test. A fixed priority encoder picks the result. The request is sampled on a valid strobe. One clock later the unit raises a single-cycle done pulse together with the accept flag, a 3-bit fault code and a flag that says the destination is now null.

Destination codes on `req_dst` are: 0 code, 1 stack, 2 to 5 the four data registers, 6 local table register, 7 task register. A selector holds the requested privilege in bits [1:0], the table indicator in bit 2 and the index from bit 3 upward.

Top module: `seg_load_chk`

## Requirements
- R1: `res_done` is high in exactly the cycle after a cycle in which `req_valid` is high, and low otherwise.
- R2: `res_accept` is high exactly when `res_fault` is 0. Fault codes are: 0 none, 1 null, 2 table limit, 3 type, 4 privilege, 5 not present.
- R3: A selector is null when bits [15:2] are all zero. A null selector gives fault 1 for the code and task registers. It gives fault 1 for the stack register outside 64-bit mode, and in 64-bit mode when CPL is 3. In every other case a null selector is accepted with `res_null` high and no further check.
- R4: A non-null selector whose last descriptor byte, the selector with bits [2:0] forced to 1, exceeds `req_tbl_limit` gives fault 2. This applies in both modes.
- R5: A code-register load needs a non-system code descriptor, else fault 3.
- R6: A stack-register load needs a non-system, writable data descriptor, else fault 3.
- R7: A data-register load (codes 2 to 5) rejects system descriptors and code descriptors that are not readable, with fault 3.
- R8: The local table register accepts only a system descriptor of type 2, and the task register only a system descriptor of type 9, else fault 3.
- R9: For data-register loads the effective privilege max(CPL, RPL) must not exceed DPL, else fault 4. A conforming code descriptor skips this rule.
- R10: For a stack-register load the effective privilege must equal DPL, else fault 4.
- R11: A non-conforming code-register load needs DPL equal to CPL and RPL not above CPL. A conforming one needs DPL not above CPL, and RPL is ignored. Otherwise fault 4.
- R12: A descriptor that passes every other check but has its present bit clear gives fault 5.
- R13: When several checks fail, the lowest-numbered fault code is reported.
- R14: While reset is applied, `res_done`, `res_accept`, `res_fault` and `res_null` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_dst | input | 3 | Destination register code |
| req_sel | input | 16 | Selector to load |
| req_cpl | input | 2 | Current privilege level |
| req_long | input | 1 | 64-bit mode active |
| req_tbl_limit | input | 16 | Descriptor table limit in bytes |
| dsc_sys | input | 1 | Descriptor is a system descriptor |
| dsc_code | input | 1 | Non-system descriptor is code |
| dsc_rd | input | 1 | Code descriptor is readable |
| dsc_wr | input | 1 | Data descriptor is writable |
| dsc_conf | input | 1 | Code descriptor is conforming |
| dsc_dpl | input | 2 | Descriptor privilege level |
| dsc_present | input | 1 | Present bit |
| dsc_systype | input | 4 | System descriptor type |
| res_done | output | 1 | One-cycle result pulse |
| res_accept | output | 1 | Load accepted |
| res_fault | output | 3 | Fault cause code |
| res_null | output | 1 | Destination loaded as null |

## Verification
The assertions assume that no request is raised in the two cycles after reset release, while the internal reset synchronizer is still holding the result registers. They also assume that descriptor attribute inputs are stable in the cycle that `req_valid` is high. The stimulus drives every request on the falling edge, waits four cycles after reset before the first request, and spaces requests so that each done pulse can be seen falling. The sweeps cover every destination, mode, CPL, RPL and DPL over a fixed set of descriptor profiles, plus null, table-indicator and limit-edge selectors.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  localparam int FLT_W = 3;

  typedef enum logic [2:0] {
    DST_CS   = 3'd0,
    DST_SS   = 3'd1,
    DST_DS   = 3'd2,
    DST_ES   = 3'd3,
    DST_FS   = 3'd4,
    DST_GS   = 3'd5,
    DST_LDTR = 3'd6,
    DST_TR   = 3'd7
  } seg_dst_e;

  typedef enum logic [FLT_W-1:0] {
    FLT_NONE   = 3'd0,
    FLT_NULL   = 3'd1,
    FLT_LIMIT  = 3'd2,
    FLT_TYPE   = 3'd3,
    FLT_PRIV   = 3'd4,
    FLT_ABSENT = 3'd5
  } seg_flt_e;

  function automatic logic is_data_dst(input seg_dst_e d);
    return (d == DST_DS) || (d == DST_ES) || (d == DST_FS) || (d == DST_GS);
  endfunction

endpackage

// File: rtl/seg_null_chk.sv
module seg_null_chk
  import seg_chk_pkg::*;
#(
  parameter int SEL_W            = 16,
  parameter int PL_W             = 2,
  parameter bit ALLOW_NULL_SS_64 = 1'b1
) (
  input  seg_dst_e              dst,
  input  logic [SEL_W-1:PL_W]   sel_hi,
  input  logic                  long_mode,
  input  logic [PL_W-1:0]       cpl,
  output logic                  is_null,
  output logic                  null_bad
);

  localparam logic [PL_W-1:0] PL_LEAST = '1;

  logic ss_bad;

  assign is_null = (sel_hi == '0);

  generate
    if (ALLOW_NULL_SS_64) begin : g_ss_relaxed
      // outside 64-bit mode always refused; inside it only at least privilege
      assign ss_bad = !long_mode || (cpl == PL_LEAST);
    end else begin : g_ss_strict
      logic unused_ok;
      assign unused_ok = long_mode ^ (^cpl);
      assign ss_bad    = 1'b1;
    end
  endgenerate

  always_comb begin
    null_bad = 1'b0;
    if (is_null) begin
      unique case (dst)
        DST_CS, DST_TR: null_bad = 1'b1;
        DST_SS:         null_bad = ss_bad;
        default:        null_bad = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/seg_type_chk.sv
module seg_type_chk
  import seg_chk_pkg::*;
#(
  parameter int                    TYPE_W   = 4,
  parameter logic [TYPE_W-1:0]     LDT_TYPE = 4'h2,
  parameter logic [TYPE_W-1:0]     TSS_TYPE = 4'h9
) (
  input  seg_dst_e              dst,
  input  logic                  d_sys,
  input  logic                  d_code,
  input  logic                  d_rd,
  input  logic                  d_wr,
  input  logic [TYPE_W-1:0]     d_systype,
  output logic                  type_ok
);

  logic is_plain_code;
  logic is_plain_data;

  assign is_plain_code = !d_sys && d_code;
  assign is_plain_data = !d_sys && !d_code;

  always_comb begin
    unique case (dst)
      DST_CS:   type_ok = is_plain_code;
      DST_SS:   type_ok = is_plain_data && d_wr;
      DST_LDTR: type_ok = d_sys && (d_systype == LDT_TYPE);
      DST_TR:   type_ok = d_sys && (d_systype == TSS_TYPE);
      default:  type_ok = is_plain_data || (is_plain_code && d_rd);
    endcase
  end

endmodule

// File: rtl/seg_priv_chk.sv
module seg_priv_chk
  import seg_chk_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  seg_dst_e              dst,
  input  logic [PL_W-1:0]       cpl,
  input  logic [PL_W-1:0]       rpl,
  input  logic [PL_W-1:0]       dpl,
  input  logic                  d_code,
  input  logic                  d_conf,
  output logic                  priv_ok
);

  logic [PL_W-1:0] epl;
  logic            conf_code;

  assign epl       = (rpl > cpl) ? rpl : cpl;
  assign conf_code = d_code && d_conf;

  always_comb begin
    unique case (dst)
      DST_CS: begin
        if (d_conf) priv_ok = (dpl <= cpl);
        else        priv_ok = (dpl == cpl) && (rpl <= cpl);
      end
      DST_SS:           priv_ok = (epl == dpl);
      DST_LDTR, DST_TR: priv_ok = 1'b1;
      default:          priv_ok = conf_code || (epl <= dpl);
    endcase
  end

endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk
  import seg_chk_pkg::*;
#(
  parameter int                SEL_W            = 16,
  parameter int                LIM_W            = 16,
  parameter int                PL_W             = 2,
  parameter int                TYPE_W           = 4,
  parameter logic [TYPE_W-1:0] LDT_TYPE         = 4'h2,
  parameter logic [TYPE_W-1:0] TSS_TYPE         = 4'h9,
  parameter bit                ALLOW_NULL_SS_64 = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [2:0]           req_dst,
  input  logic [SEL_W-1:0]     req_sel,
  input  logic [PL_W-1:0]      req_cpl,
  input  logic                 req_long,
  input  logic [LIM_W-1:0]     req_tbl_limit,
  input  logic                 dsc_sys,
  input  logic                 dsc_code,
  input  logic                 dsc_rd,
  input  logic                 dsc_wr,
  input  logic                 dsc_conf,
  input  logic [PL_W-1:0]      dsc_dpl,
  input  logic                 dsc_present,
  input  logic [TYPE_W-1:0]    dsc_systype,
  output logic                 res_done,
  output logic                 res_accept,
  output logic [FLT_W-1:0]     res_fault,
  output logic                 res_null
);

  // selector layout: [PL_W-1:0] requested level, [PL_W] table select, above: index
  localparam int IDX_LSB = PL_W + 1;
  localparam int CMP_W   = (SEL_W > LIM_W) ? SEL_W : LIM_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  seg_dst_e dst;
  assign dst = seg_dst_e'(req_dst);

  logic sel_is_null;
  logic null_bad;
  logic type_ok;
  logic priv_ok;
  logic lim_ok;

  seg_null_chk #(
    .SEL_W            (SEL_W),
    .PL_W             (PL_W),
    .ALLOW_NULL_SS_64 (ALLOW_NULL_SS_64)
  ) u_null (
    .dst       (dst),
    .sel_hi    (req_sel[SEL_W-1:PL_W]),
    .long_mode (req_long),
    .cpl       (req_cpl),
    .is_null   (sel_is_null),
    .null_bad  (null_bad)
  );

  seg_type_chk #(
    .TYPE_W   (TYPE_W),
    .LDT_TYPE (LDT_TYPE),
    .TSS_TYPE (TSS_TYPE)
  ) u_type (
    .dst       (dst),
    .d_sys     (dsc_sys),
    .d_code    (dsc_code),
    .d_rd      (dsc_rd),
    .d_wr      (dsc_wr),
    .d_systype (dsc_systype),
    .type_ok   (type_ok)
  );

  seg_priv_chk #(
    .PL_W (PL_W)
  ) u_priv (
    .dst     (dst),
    .cpl     (req_cpl),
    .rpl     (req_sel[PL_W-1:0]),
    .dpl     (dsc_dpl),
    .d_code  (dsc_code),
    .d_conf  (dsc_conf),
    .priv_ok (priv_ok)
  );

  // last byte of the addressed descriptor must lie inside the table
  logic [SEL_W-1:0] sel_last;
  assign sel_last = {req_sel[SEL_W-1:IDX_LSB], {IDX_LSB{1'b1}}};
  assign lim_ok   = (CMP_W'(sel_last) <= CMP_W'(req_tbl_limit));

  // priority encode of the parallel checks
  seg_flt_e flt_d;
  logic     acc_d;
  logic     nul_d;

  always_comb begin
    nul_d = 1'b0;
    if (sel_is_null) begin
      flt_d = null_bad ? FLT_NULL : FLT_NONE;
      nul_d = !null_bad;
    end else if (!lim_ok) begin
      flt_d = FLT_LIMIT;
    end else if (!type_ok) begin
      flt_d = FLT_TYPE;
    end else if (!priv_ok) begin
      flt_d = FLT_PRIV;
    end else if (!dsc_present) begin
      flt_d = FLT_ABSENT;
    end else begin
      flt_d = FLT_NONE;
    end
    acc_d = (flt_d == FLT_NONE);
  end

  // result registers
  logic             done_q;
  logic             acc_q;
  logic             nul_q;
  logic [FLT_W-1:0] flt_q;
  logic             res_en;

  assign res_en = req_valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
      acc_q  <= 1'b0;
      nul_q  <= 1'b0;
      flt_q  <= '0;
    end else begin
      done_q <= req_valid;
      if (res_en) begin
        acc_q <= acc_d;
        nul_q <= nul_d;
        flt_q <= flt_d;
      end
    end
  end

  assign res_done   = done_q;
  assign res_accept = acc_q;
  assign res_fault  = flt_q;
  assign res_null   = nul_q;

endmodule

// File: rtl/seg_load_chk_sva.sv
module seg_load_chk_sva #(
  parameter int SEL_W = 16,
  parameter int LIM_W = 16,
  parameter int PL_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_dst,
  input logic [SEL_W-1:0] req_sel,
  input logic [LIM_W-1:0] req_tbl_limit,
  input logic             dsc_sys,
  input logic             dsc_code,
  input logic             res_done,
  input logic             res_accept,
  input logic [2:0]       res_fault,
  input logic             res_null
);

  localparam int IDX_LSB = PL_W + 1;

  logic sel_null;
  logic over_lim;
  assign sel_null = (req_sel[SEL_W-1:PL_W] == '0);
  assign over_lim = (32'({req_sel[SEL_W-1:IDX_LSB], {IDX_LSB{1'b1}}}) > 32'(req_tbl_limit));

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_done); // R1
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_done); // R1
  AST_ACCEPT_IFF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (res_accept == (res_fault == 3'd0))); // R2
  AST_CS_NULL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_dst == 3'd0 && sel_null) |=> (res_fault == 3'd1)); // R3
  AST_DATA_NULL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_dst >= 3'd2 && req_dst <= 3'd5 && sel_null) |=> (res_accept && res_null)); // R3
  AST_NULL_FLAG_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_null) |-> res_accept); // R3
  AST_LIMIT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sel_null && over_lim) |=> (res_fault == 3'd2)); // R4
  AST_SS_NOT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_dst == 3'd1 && !sel_null && !dsc_sys && dsc_code) |=> !res_accept); // R6
  AST_TR_NEEDS_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_dst == 3'd7 && !sel_null && !dsc_sys) |=> !res_accept); // R8
  AST_FAULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (res_fault <= 3'd5)); // R13

endmodule

bind seg_load_chk seg_load_chk_sva #(
  .SEL_W (SEL_W),
  .LIM_W (LIM_W),
  .PL_W  (PL_W)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .req_valid     (req_valid),
  .req_dst       (req_dst),
  .req_sel       (req_sel),
  .req_tbl_limit (req_tbl_limit),
  .dsc_sys       (dsc_sys),
  .dsc_code      (dsc_code),
  .res_done      (res_done),
  .res_accept    (res_accept),
  .res_fault     (res_fault),
  .res_null      (res_null)
);

// File: tb/seg_load_chk_tb.sv
module seg_load_chk_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_dst;
  logic [15:0] req_sel;
  logic [1:0]  req_cpl;
  logic        req_long;
  logic [15:0] req_tbl_limit;
  logic        dsc_sys, dsc_code, dsc_rd, dsc_wr, dsc_conf, dsc_present;
  logic [1:0]  dsc_dpl;
  logic [3:0]  dsc_systype;
  logic        res_done, res_accept, res_null;
  logic [2:0]  res_fault;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  seg_load_chk u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_dst       (req_dst),
    .req_sel       (req_sel),
    .req_cpl       (req_cpl),
    .req_long      (req_long),
    .req_tbl_limit (req_tbl_limit),
    .dsc_sys       (dsc_sys),
    .dsc_code      (dsc_code),
    .dsc_rd        (dsc_rd),
    .dsc_wr        (dsc_wr),
    .dsc_conf      (dsc_conf),
    .dsc_dpl       (dsc_dpl),
    .dsc_present   (dsc_present),
    .dsc_systype   (dsc_systype),
    .res_done      (res_done),
    .res_accept    (res_accept),
    .res_fault     (res_fault),
    .res_null      (res_null)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // descriptor profiles: 0 rw data, 1 ro data, 2 exec-only code, 3 readable code,
  // 4 conforming readable code, 5 system type 2, 6 system type 9, 7 system type 12
  task automatic set_profile(input int p);
    dsc_sys = (p >= 5);
    dsc_code = (p >= 2 && p <= 4);
    dsc_rd = (p == 0 || p == 1 || p == 3 || p == 4);
    dsc_wr = (p == 0);
    dsc_conf = (p == 4);
    dsc_systype = (p == 5) ? 4'd2 : (p == 6) ? 4'd9 : (p == 7) ? 4'd12 : 4'd0;
  endtask

  // expected outcome computed from the requirements
  task automatic model(output int f, output int nl, output string tag);
    int rpl, epl, dpl, cpl, dst;
    bit tok, pok;
    dst = req_dst; cpl = req_cpl; dpl = dsc_dpl; rpl = req_sel[1:0];
    epl = (rpl > cpl) ? rpl : cpl;
    nl = 0; f = 0; tag = "R2";
    if (req_sel[15:2] == 0) begin                       // R3
      tag = "R3";
      if (dst == 0 || dst == 7) f = 1;
      else if (dst == 1 && (!req_long || cpl == 3)) f = 1;
      else nl = 1;
      return;
    end
    if (int'({req_sel[15:3], 3'b111}) > int'(req_tbl_limit)) begin
      f = 2; tag = "R4"; return;
    end
    case (dst)
      0: begin tok = !dsc_sys && dsc_code; tag = "R5"; end
      1: begin tok = !dsc_sys && !dsc_code && dsc_wr; tag = "R6"; end
      6: begin tok = dsc_sys && dsc_systype == 4'd2; tag = "R8"; end
      7: begin tok = dsc_sys && dsc_systype == 4'd9; tag = "R8"; end
      default: begin tok = !dsc_sys && (!dsc_code || dsc_rd); tag = "R7"; end
    endcase
    if (!tok) begin f = 3; return; end
    case (dst)
      0: begin pok = dsc_conf ? (dpl <= cpl) : (dpl == cpl && rpl <= cpl); tag = "R11"; end
      1: begin pok = (epl == dpl); tag = "R10"; end
      6, 7: begin pok = 1; tag = "R2"; end
      default: begin pok = (dsc_code && dsc_conf) || (epl <= dpl); tag = "R9"; end
    endcase
    if (!pok) begin f = 4; return; end
    if (!dsc_present) begin f = 5; tag = "R12"; return; end
    tag = "R2";
  endtask

  task automatic run_txn();
    int ef, en;
    string tag;
    model(ef, en, tag);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(res_done == 1'b1, "R1 done after request", res_done, 1);
    // R13: the model reports the lowest failing code
    check(res_fault == 3'(ef), {tag, " R13 fault code"}, res_fault, ef);
    check(res_accept == (ef == 0), {tag, " R2 accept"}, res_accept, ef == 0);
    check(res_null == en[0], {tag, " R3 null flag"}, res_null, en);
    @(negedge clk);
    check(res_done == 1'b0, "R1 done single cycle", res_done, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_dst = '0; req_sel = '0; req_cpl = '0;
    req_long = 1'b0; req_tbl_limit = 16'h00FF; dsc_dpl = '0; dsc_present = 1'b1;
    set_profile(0);
    repeat (3) @(negedge clk);
    // R14: outputs idle during reset
    check(res_done == 0 && res_accept == 0 && res_fault == 0 && res_null == 0,
          "R14 reset state", {res_done, res_accept, res_fault, res_null}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // sweep A: index 5 inside limit, all privilege combinations and profiles
    for (int d = 0; d < 8; d++)
      for (int lg = 0; lg < 2; lg++)
        for (int c = 0; c < 4; c++)
          for (int r = 0; r < 4; r++)
            for (int dp = 0; dp < 4; dp++)
              for (int p = 0; p < 8; p++)
                for (int pr = 0; pr < 2; pr++) begin
                  req_dst = 3'(d); req_long = lg[0]; req_cpl = 2'(c);
                  req_sel = {13'd5, 1'b0, 2'(r)}; req_tbl_limit = 16'h00FF;
                  dsc_dpl = 2'(dp); dsc_present = pr[0];
                  set_profile(p);
                  run_txn();
                end

    // sweep B: null, table-select, and limit-edge selectors (R3, R4, R13)
    for (int d = 0; d < 8; d++)
      for (int lg = 0; lg < 2; lg++)
        for (int c = 0; c < 4; c++)
          for (int s = 0; s < 6; s++)
            for (int p = 0; p < 8; p++)
              for (int pr = 0; pr < 2; pr++) begin
                req_dst = 3'(d); req_long = lg[0]; req_cpl = 2'(c);
                case (s)
                  0: req_sel = 16'h0000;
                  1: req_sel = 16'h0003;
                  2: req_sel = 16'h0004;
                  3: req_sel = {13'd31, 3'b000};
                  4: req_sel = {13'd32, 3'b000};
                  default: req_sel = {13'd32, 3'b111};
                endcase
                req_tbl_limit = 16'h00FF;
                dsc_dpl = 2'(c); dsc_present = pr[0];
                set_profile(p);
                run_txn();
              end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule